// File: doc/BRIEF.md
# Temperature Monitor Interrupt Controller

This block connects a temperature A/D converter to a small host register port. A host write with bit 7 set to the control register starts one conversion. The block holds a request line high until the converter answers with a done pulse and a signed temperature byte. It then latches the reading into the value register at address 0x00 and sets a conversion-complete flag.

Each new reading is compared as a signed whole-degree value against a hot threshold and a cold threshold. Each threshold is a 4-bit code that maps to degrees as `THR_OFFSET + THR_STEP * code`. The reading is also compared against a baseline that updates itself: a difference of at least the programmed delta, in either direction, raises a drift event and moves the baseline to the new reading. The end-of-conversion, hot, cold and drift events each set a sticky status bit. Each status bit has its own enable. The registered, active-low interrupt output is low while any enabled status bit is set. Clearing an enable releases the interrupt output, and the host can still poll the status bit.

Register map (3-bit address): 0 = reading (read only), 1 = status (read clears), 2 = interrupt enables, 3 = thresholds (hot code in [7:4], cold code in [3:0]), 4 = drift delta, 5 = control. Status and enable bit positions are: bit 0 end of conversion, bit 1 hot, bit 2 cold, bit 3 drift. Control reads return busy in bit 7 and conversion done in bit 6. Read data appears on `host_rdata` one clock after `host_rd`. Reset is synchronous and active high.

Top module: `temp_irq_ctrl`

## Requirements
- R1: A write to address 5 with bit 7 set, while no conversion is running, raises `adc_req` on the next clock and sets control bit 7 (busy). It also clears control bit 6.
- R2: A start write while `adc_req` is high is ignored: only one done pulse is needed to finish the conversion, and `adc_req` stays low afterwards. A done pulse while idle is ignored, and the stored reading does not change.
- R3: On a done pulse during a conversion, `adc_req` falls on the next clock. The reading becomes readable at address 0, status bit 0 is set, and control bit 6 reads 1.
- R4: A reading greater than or equal to `THR_OFFSET + THR_STEP*hot_code` sets status bit 1. With the defaults (hot code 12) the threshold is 50.
- R5: A reading less than or equal to `THR_OFFSET + THR_STEP*cold_code` sets status bit 2. With the defaults (cold code 2) the threshold is 0.
- R6: A reading whose absolute difference from the baseline is at least the delta (reset value 2) sets status bit 3 and becomes the new baseline. A smaller difference leaves both the status and the baseline unchanged.
- R7: The first reading after reset loads the baseline and does not set status bit 3.
- R8: Status bits are sticky. A read of address 1 returns them and clears them, except for a bit set by a reading that lands in the same cycle.
- R9: `irq_n` is low exactly when a status bit and its enable were both set on the previous clock. The drift enable resets to 0, so drift alone does not assert `irq_n`. Clearing an enable releases `irq_n` but keeps the status bit.
- R10: After reset, `irq_n` is 1, `adc_req` is 0, the enables read 0x07, the thresholds read 0xC2, the delta reads 0x02 and the status reads 0x00.
- R11: Readings and thresholds are compared as signed two's-complement values, so a reading of 0x80 is -128 and never reaches a positive hot threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| adc_req | output | 1 | Conversion request, held until done |
| adc_done | input | 1 | Converter done pulse |
| adc_data | input | 8 | Signed temperature reading |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check the converter handshake on every cycle: a request is held until done, it drops after done, and a start while idle raises it. They also check that `irq_n` stays high when all enables are zero, that a status read empties the status, and that reset values appear at the ports. Only the bench scenarios can show the arithmetic behaviour. That covers the threshold edges, signed comparison, the drift boundary at exactly the delta, whether the baseline was kept or moved, the silent first reading and the polling of status after an enable is cleared.

// File: rtl/tmon_pkg.sv
`timescale 1ns/1ps
package tmon_pkg;
  localparam int ADDR_W = 3;
  localparam int NIRQ   = 4;

  // status / enable bit positions
  localparam int IRQ_EOC   = 0;
  localparam int IRQ_HOT   = 1;
  localparam int IRQ_COLD  = 2;
  localparam int IRQ_DRIFT = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] A_TEMP  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd2;
  localparam logic [ADDR_W-1:0] A_THR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DELTA = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;

  // control register bit positions
  localparam int CTRL_GO   = 7;
  localparam int CTRL_BUSY = 7;
  localparam int CTRL_DONE = 6;
endpackage

// File: rtl/tmon_conv.sv
`timescale 1ns/1ps
module tmon_conv #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              busy,
  output logic              conv_done,
  output logic              smp_vld,
  output logic [DATA_W-1:0] smp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      conv_done <= 1'b0;
      smp_vld   <= 1'b0;
      smp_data  <= '0;
    end else begin
      smp_vld <= 1'b0;
      if (busy && adc_done) begin
        busy      <= 1'b0;
        conv_done <= 1'b1;
        smp_vld   <= 1'b1;
        smp_data  <= adc_data;
      end else if (!busy && start_req) begin
        busy      <= 1'b1;
        conv_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmon_eval.sv
`timescale 1ns/1ps
module tmon_eval #(
  parameter int DATA_W     = 8,
  parameter int CODE_W     = 4,
  parameter int THR_STEP   = 5,
  parameter int THR_OFFSET = -10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [CODE_W-1:0] hot_code,
  input  logic [CODE_W-1:0] cold_code,
  input  logic [DATA_W-1:0] delta,
  output logic              hot_hit,
  output logic              cold_hit,
  output logic              drift_hit
);
  // two guard bits hold every threshold and every reading difference
  localparam int CW = DATA_W + 2;

  logic signed [CW-1:0] hot_t, cold_t, rd_s, base_s, diff, mag, delta_s;
  logic [DATA_W-1:0]    base_q;
  logic                 base_vld;

  assign hot_t   = CW'(THR_OFFSET + THR_STEP * int'(hot_code));
  assign cold_t  = CW'(THR_OFFSET + THR_STEP * int'(cold_code));
  assign rd_s    = {{2{smp_data[DATA_W-1]}}, smp_data};
  assign base_s  = {{2{base_q[DATA_W-1]}}, base_q};
  assign delta_s = {2'b00, delta};
  assign diff    = rd_s - base_s;
  assign mag     = diff[CW-1] ? -diff : diff;

  assign hot_hit   = (rd_s >= hot_t);
  assign cold_hit  = (rd_s <= cold_t);
  assign drift_hit = base_vld && (mag >= delta_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      base_vld <= 1'b0;
    end else if (smp_vld) begin
      base_vld <= 1'b1;
      if (!base_vld || drift_hit) base_q <= smp_data;
    end
  end
endmodule

// File: rtl/tmon_regs.sv
`timescale 1ns/1ps
module tmon_regs
  import tmon_pkg::*;
#(
  parameter int                DATA_W        = 8,
  parameter int                CODE_W        = 4,
  parameter logic [CODE_W-1:0] HOT_CODE_RST  = 4'd12,
  parameter logic [CODE_W-1:0] COLD_CODE_RST = 4'd2,
  parameter logic [DATA_W-1:0] DELTA_RST     = 8'd2,
  parameter logic [NIRQ-1:0]   IEN_RST       = 4'b0111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n,
  output logic              start_req,
  input  logic              busy,
  input  logic              conv_done,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              hot_hit,
  input  logic              cold_hit,
  input  logic              drift_hit,
  output logic [CODE_W-1:0] hot_code,
  output logic [CODE_W-1:0] cold_code,
  output logic [DATA_W-1:0] delta,
  output logic [NIRQ-1:0]   ien,
  output logic [NIRQ-1:0]   status
);
  logic [DATA_W-1:0] temp_q;
  logic [NIRQ-1:0]   set_v;
  logic              stat_rd;
  logic [DATA_W-1:0] rd_mux;

  assign start_req = wr_en && (addr == A_CTRL) && wdata[CTRL_GO];
  assign stat_rd   = rd_en && (addr == A_STAT);

  always_comb begin
    set_v = '0;
    if (smp_vld) begin
      set_v[IRQ_EOC]   = 1'b1;
      set_v[IRQ_HOT]   = hot_hit;
      set_v[IRQ_COLD]  = cold_hit;
      set_v[IRQ_DRIFT] = drift_hit;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_TEMP:  rd_mux = temp_q;
      A_STAT:  rd_mux = DATA_W'(status);
      A_IEN:   rd_mux = DATA_W'(ien);
      A_THR:   rd_mux = DATA_W'({hot_code, cold_code});
      A_DELTA: rd_mux = delta;
      A_CTRL: begin
        rd_mux[CTRL_BUSY] = busy;
        rd_mux[CTRL_DONE] = conv_done;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hot_code  <= HOT_CODE_RST;
      cold_code <= COLD_CODE_RST;
      delta     <= DELTA_RST;
      ien       <= IEN_RST;
    end else if (wr_en) begin
      case (addr)
        A_IEN:   ien <= wdata[NIRQ-1:0];
        A_THR: begin
          hot_code  <= wdata[2*CODE_W-1:CODE_W];
          cold_code <= wdata[CODE_W-1:0];
        end
        A_DELTA: delta <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      temp_q <= '0;
      rdata  <= '0;
      irq_n  <= 1'b1;
    end else begin
      status <= (stat_rd ? '0 : status) | set_v;
      if (smp_vld) temp_q <= smp_data;
      if (rd_en) rdata <= rd_mux;
      irq_n <= ~|(status & ien);
    end
  end
endmodule

// File: rtl/temp_irq_ctrl.sv
`timescale 1ns/1ps
module temp_irq_ctrl
  import tmon_pkg::*;
#(
  parameter int                DATA_W        = 8,
  parameter int                CODE_W        = 4,
  parameter int                THR_STEP      = 5,
  parameter int                THR_OFFSET    = -10,
  parameter logic [CODE_W-1:0] HOT_CODE_RST  = 4'd12,
  parameter logic [CODE_W-1:0] COLD_CODE_RST = 4'd2,
  parameter logic [DATA_W-1:0] DELTA_RST     = 8'd2,
  parameter logic [NIRQ-1:0]   IEN_RST       = 4'b0111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              adc_req,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              irq_n
);
  logic              start_req, busy, conv_done, smp_vld;
  logic [DATA_W-1:0] smp_data, delta;
  logic [CODE_W-1:0] hot_code, cold_code;
  logic              hot_hit, cold_hit, drift_hit;
  logic [NIRQ-1:0]   ien, status;

  tmon_conv #(.DATA_W(DATA_W)) u_conv (
    .clk(clk), .rst(rst), .start_req(start_req),
    .adc_done(adc_done), .adc_data(adc_data),
    .busy(busy), .conv_done(conv_done),
    .smp_vld(smp_vld), .smp_data(smp_data)
  );

  assign adc_req = busy;

  tmon_eval #(
    .DATA_W(DATA_W), .CODE_W(CODE_W),
    .THR_STEP(THR_STEP), .THR_OFFSET(THR_OFFSET)
  ) u_eval (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
    .hot_code(hot_code), .cold_code(cold_code), .delta(delta),
    .hot_hit(hot_hit), .cold_hit(cold_hit), .drift_hit(drift_hit)
  );

  tmon_regs #(
    .DATA_W(DATA_W), .CODE_W(CODE_W),
    .HOT_CODE_RST(HOT_CODE_RST), .COLD_CODE_RST(COLD_CODE_RST),
    .DELTA_RST(DELTA_RST), .IEN_RST(IEN_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(host_wr), .rd_en(host_rd),
    .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
    .irq_n(irq_n), .start_req(start_req),
    .busy(busy), .conv_done(conv_done),
    .smp_vld(smp_vld), .smp_data(smp_data),
    .hot_hit(hot_hit), .cold_hit(cold_hit), .drift_hit(drift_hit),
    .hot_code(hot_code), .cold_code(cold_code), .delta(delta),
    .ien(ien), .status(status)
  );
endmodule

// File: rtl/tmon_chk.sv
`timescale 1ns/1ps
module tmon_chk
  import tmon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              adc_req,
  input logic              adc_done,
  input logic              irq_n,
  input logic              smp_vld,
  input logic [NIRQ-1:0]   ien,
  input logic [NIRQ-1:0]   status
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R10: the cycle after reset shows idle outputs
  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      p_rst_idle_r10: assert (irq_n && !adc_req)
        else $error("R10 outputs not idle after reset");
    end
  end

  // R1: start while idle raises the request
  p_start_req_r1: assert property (@(posedge clk) disable iff (rst)
    (!adc_req && host_wr && host_addr == A_CTRL && host_wdata[CTRL_GO]) |=> adc_req);

  // R2: request held until done
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (adc_req && !adc_done) |=> adc_req);

  // R3: request released after done
  p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (adc_req && adc_done) |=> !adc_req);

  // R8: a status read with no reading landing empties the status
  p_stat_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == A_STAT && !smp_vld) |=> (status == '0));

  // R9: with every enable cleared the interrupt stays released
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> irq_n);
endmodule

bind temp_irq_ctrl tmon_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata),
  .adc_req(adc_req), .adc_done(adc_done), .irq_n(irq_n),
  .smp_vld(smp_vld), .ien(ien), .status(status)
);

// File: tb/test_temp_irq_ctrl.sv
`timescale 1ns/1ps
module test_temp_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       adc_req, adc_done = 1'b0, irq_n;
  logic [7:0] adc_data = '0;

  int n_run = 0, n_fail = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  temp_irq_ctrl i_temp_irq_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .adc_req(adc_req), .adc_done(adc_done), .adc_data(adc_data), .irq_n(irq_n)
  );

  // {reading, expected status} under default settings, from reset
  localparam logic [11:0] VEC [0:9] = '{
    {8'd20,  4'h1},  // first reading: baseline only (R7)
    {8'd21,  4'h1},  // diff 1 < 2
    {8'd22,  4'h9},  // diff 2: drift
    {8'd50,  4'hB},  // hot at threshold 50, drift
    {8'd49,  4'h1},  // below hot, diff 1
    {8'd0,   4'hD},  // cold at threshold 0, drift
    {8'hFB,  4'hD},  // -5 cold, drift
    {8'hFC,  4'h5},  // -4 cold, diff 1
    {8'h7F,  4'hB},  // 127 hot, drift
    {8'h80,  4'hD}   // -128 cold, drift
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic done_pulse(input logic [7:0] d);
    @(negedge clk);
    adc_done = 1'b1; adc_data = d;
    @(negedge clk);
    adc_done = 1'b0;
  endtask

  task automatic run_conv(input logic [7:0] d);
    host_write(3'd5, 8'h80);
    check("R1 request raised", {7'd0, adc_req}, 8'd1);
    done_pulse(d);
    check("R3 request dropped", {7'd0, adc_req}, 8'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    check("R10 irq_n", {7'd0, irq_n}, 8'd1);
    check("R10 adc_req", {7'd0, adc_req}, 8'd0);
    host_read(3'd2, rv); check("R10 enables", rv, 8'h07);
    host_read(3'd3, rv); check("R10 thresholds", rv, 8'hC2);
    host_read(3'd4, rv); check("R10 delta", rv, 8'h02);
    host_read(3'd1, rv); check("R10 status", rv, 8'h00);

    // vector table: R4 R5 R6 R7 R11 under defaults
    for (int i = 0; i < 10; i++) begin
      run_conv(VEC[i][11:4]);
      check("R9 irq on eoc", {7'd0, irq_n}, 8'd0);
      host_read(3'd1, rv);
      check("R4 R5 R6 R7 R11 status", rv, {4'd0, VEC[i][3:0]});
      host_read(3'd0, rv);
      check("R3 reading", rv, VEC[i][11:4]);
      check("R8 irq released after read", {7'd0, irq_n}, 8'd1);
      host_read(3'd1, rv);
      check("R8 status cleared", rv, 8'h00);
    end

    // R2: second start while busy is ignored
    host_write(3'd5, 8'h80);
    host_write(3'd5, 8'h80);
    host_read(3'd5, rv); check("R1 busy set done cleared", rv, 8'h80);
    done_pulse(8'd30);
    repeat (4) @(negedge clk);
    check("R2 no second conversion", {7'd0, adc_req}, 8'd0);
    host_read(3'd5, rv); check("R3 done flag", rv, 8'h40);
    host_read(3'd1, rv); check("R2 single result", rv, 8'h09);
    // R2: done pulse while idle is ignored
    done_pulse(8'd99);
    repeat (2) @(negedge clk);
    host_read(3'd0, rv); check("R2 idle done ignored", rv, 8'd30);
    host_read(3'd1, rv); check("R2 idle done no status", rv, 8'h00);

    // R9: enable masking and polling
    host_write(3'd2, 8'h02);
    run_conv(8'd60);
    check("R9 hot asserts irq", {7'd0, irq_n}, 8'd0);
    host_write(3'd2, 8'h00);
    repeat (2) @(negedge clk);
    check("R9 cleared enable releases irq", {7'd0, irq_n}, 8'd1);
    host_read(3'd1, rv); check("R9 hot still pollable", rv, 8'h0B);
    host_write(3'd2, 8'h06);
    run_conv(8'd40);
    check("R9 drift masked", {7'd0, irq_n}, 8'd1);
    host_write(3'd2, 8'h08);
    repeat (2) @(negedge clk);
    check("R9 drift enabled asserts irq", {7'd0, irq_n}, 8'd0);
    host_read(3'd1, rv); check("R9 drift status", rv, 8'h09);

    // R11 signed thresholds: hot code 1 -> -5, cold code 0 -> -10
    host_write(3'd3, 8'h10);
    run_conv(8'hFB);
    host_read(3'd1, rv); check("R11 R4 hot at -5", rv, 8'h0B);
    run_conv(8'hF6);
    host_read(3'd1, rv); check("R11 R5 cold at -10", rv, 8'h0D);

    // R6 programmed delta 5, baseline kept on small change
    host_write(3'd4, 8'd5);
    run_conv(8'hFA);
    host_read(3'd1, rv); check("R6 diff 4 below delta", rv, 8'h01);
    run_conv(8'hFB);
    host_read(3'd1, rv); check("R6 baseline kept, diff 5", rv, 8'h0B);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule